// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual page number that missed in the translation buffer. It walks a two-level page table held in memory and issues one 32-bit word read at a time on a simple request/response port. The walk starts from a root physical page number. Each entry it reads either points to a second-level table or is a leaf. A leaf found at the first level maps a 4 MB superpage. A leaf found at the second level maps a 4 KB page.

When the walk reaches a leaf, the block checks the requested access (load, store or fetch) at the requested privilege against the leaf's permission bits. It then raises either a one-cycle done pulse, with the translation to refill the buffer, or a one-cycle fault pulse. The block takes one walk at a time and reports busy for as long as a walk is in progress.

Top module: `ptw_engine`

## Requirements
- R1: A walk is accepted when `req_valid_i` is high in a cycle where `busy_o` is low. `req_vpn_i`, `req_acc_i`, `req_user_i` and `root_ppn_i` are captured in that cycle. The first read is requested in the following cycle, at address `root_ppn*4096 + req_vpn[19:10]*4`. Exactly one request is outstanding at a time, and `mem_req_o` is high for one cycle per read.
- R2: An entry holds the physical page number in bits 31..10, valid in bit 0, read in bit 1, write in bit 2, execute in bit 3 and user in bit 4. A valid first-level entry whose read, write and execute bits are all zero is a pointer. The walk then reads `entry_ppn*4096 + req_vpn[9:0]*4`.
- R3: A valid leaf at the first level that passes its checks gives `done_o` with `res_super_o`=1. `res_ppn_o` is then entry bits 31..20 concatenated with `req_vpn[9:0]`.
- R4: A valid leaf at the second level that passes its checks gives `done_o` with `res_super_o`=0 and `res_ppn_o` equal to the entry's page number.
- R5: An entry with bit 0 clear, at either level, ends the walk with `fault_o`. No further read is issued.
- R6: An entry with write set and read clear is reserved and ends the walk with `fault_o`.
- R7: A pointer found at the second level ends the walk with `fault_o`.
- R8: A first-level leaf whose entry bits 19..10 are not all zero is a misaligned superpage and ends the walk with `fault_o`.
- R9: `req_acc_i` uses 0 for load, 1 for store, 2 for fetch and 3 for reserved. A load needs read, a store needs write and a fetch needs execute. The reserved code always faults. A failed check raises `fault_o`.
- R10: With `req_user_i`=1 (user mode) the leaf's user bit must be set. With `req_user_i`=0 (supervisor mode) a leaf with the user bit set is denied. Either violation raises `fault_o`.
- R11: `done_o` and `fault_o` are never high together, and each is high for one cycle. `busy_o` is high from the cycle after acceptance through the pulse cycle, and low in the cycle after the pulse.
- R12: `req_valid_i` and changes on `root_ppn_i` while `busy_o` is high do not affect the walk in progress or its result.
- R13: While reset is asserted, `busy_o`, `mem_req_o`, `done_o` and `fault_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk |
| req_vpn_i | input | 20 | Virtual page number that missed |
| req_acc_i | input | 2 | Access type: 0 load, 1 store, 2 fetch, 3 reserved |
| req_user_i | input | 1 | 1 = user mode, 0 = supervisor mode |
| root_ppn_i | input | 22 | Root table page number from the translation control register |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Read request, one cycle |
| mem_addr_o | output | 34 | Physical byte address of the entry |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Entry read from memory |
| done_o | output | 1 | One-cycle pulse: translation ready |
| fault_o | output | 1 | One-cycle pulse: page fault |
| res_ppn_o | output | 22 | Physical page number of the translated address |
| res_super_o | output | 1 | Translation is a 4 MB superpage |
| res_flags_o | output | 10 | Low ten bits of the leaf entry |

## Verification
A wrong walker state shows up at the ports within the walk it corrupts, and usually within one or two cycles:
- A wrong index or base shows as a mismatched read address.
- A missed or extra descent shows as the wrong number of reads.
- A wrong decode or a wrong permission decision flips a done pulse into a fault pulse, or the reverse, in the pulse cycle.
- A stuck state shows as `busy_o` still high in the cycle after the pulse.

The bench counts reads and logs their addresses per walk. It compares the outcome with a model of the table in the bench, and checks the idle cycle after every pulse.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_L1,
    ST_WT_L1,
    ST_RD_L2,
    ST_WT_L2,
    ST_DONE,
    ST_FAULT
  } walk_st_e;
endpackage

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PTE_W  = 32,
  parameter int PPN_W  = 22,
  localparam int FLG_W = PTE_W - PPN_W
) (
  input  logic [PTE_W-1:0] pte_i,
  output logic [PPN_W-1:0] ppn_o,
  output logic [FLG_W-1:0] flags_o,
  output logic             valid_o,
  output logic             rsvd_o,
  output logic             ptr_o,
  output logic             r_o,
  output logic             w_o,
  output logic             x_o,
  output logic             u_o
);
  assign ppn_o   = pte_i[PTE_W-1 -: PPN_W];
  assign flags_o = pte_i[FLG_W-1:0];
  assign valid_o = pte_i[0];
  assign r_o     = pte_i[1];
  assign w_o     = pte_i[2];
  assign x_o     = pte_i[3];
  assign u_o     = pte_i[4];
  // write without read is an unassigned encoding
  assign rsvd_o  = pte_i[2] & ~pte_i[1];
  assign ptr_o   = ~(pte_i[1] | pte_i[2] | pte_i[3]);
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
  import ptw_pkg::*;
(
  input  acc_e acc_i,
  input  logic user_i,
  input  logic r_i,
  input  logic w_i,
  input  logic x_i,
  input  logic u_i,
  output logic ok_o
);
  logic type_ok;
  always_comb begin
    unique case (acc_i)
      ACC_LOAD:  type_ok = r_i;
      ACC_STORE: type_ok = w_i;
      ACC_FETCH: type_ok = x_i;
      default:   type_ok = 1'b0;
    endcase
  end
  // user pages only from user mode, and user mode only on user pages
  assign ok_o = type_ok & (user_i == u_i);
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int PPN_W    = 22,
  parameter int IDX_W    = 10,
  parameter int PTE_LOG2 = 2,
  localparam int ADDR_W  = PPN_W + IDX_W + PTE_LOG2
) (
  input  logic [PPN_W-1:0]  ppn_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  assign addr_o = {ppn_i, idx_i, {PTE_LOG2{1'b0}}};
endmodule

// File: rtl/ptw_engine.sv
module ptw_engine
  import ptw_pkg::*;
#(
  parameter int PA_W     = 34,
  parameter int PG_OFS_W = 12,
  parameter int IDX_W    = 10,
  parameter int PTE_W    = 32,
  localparam int PPN_W   = PA_W - PG_OFS_W,
  localparam int VPN_W   = 2 * IDX_W,
  localparam int FLG_W   = PTE_W - PPN_W,
  localparam int LVLS    = 2,
  localparam int PTE_LOG2 = PG_OFS_W - IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VPN_W-1:0] req_vpn_i,
  input  logic [1:0]       req_acc_i,
  input  logic             req_user_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             busy_o,
  output logic             mem_req_o,
  output logic [PA_W-1:0]  mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [PTE_W-1:0] mem_rdata_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [PPN_W-1:0] res_ppn_o,
  output logic             res_super_o,
  output logic [FLG_W-1:0] res_flags_o
);
  walk_st_e         state_q, state_d;
  logic [VPN_W-1:0] vpn_q;
  acc_e             acc_q;
  logic             user_q;
  logic [PPN_W-1:0] root_q, ptr_q;
  logic [PPN_W-1:0] res_ppn_q;
  logic             res_super_q;
  logic [FLG_W-1:0] res_flags_q;

  // level 0 index is the upper half of the page number
  logic [IDX_W-1:0] lvl_idx  [LVLS];
  logic [PPN_W-1:0] lvl_base [LVLS];
  logic [PA_W-1:0]  lvl_addr [LVLS];

  assign lvl_idx[0]  = vpn_q[VPN_W-1 -: IDX_W];
  assign lvl_idx[1]  = vpn_q[IDX_W-1:0];
  assign lvl_base[0] = root_q;
  assign lvl_base[1] = ptr_q;

  for (genvar lv = 0; lv < LVLS; lv++) begin : g_lvl
    ptw_addr_gen #(
      .PPN_W(PPN_W), .IDX_W(IDX_W), .PTE_LOG2(PTE_LOG2)
    ) u_ag (
      .ppn_i (lvl_base[lv]),
      .idx_i (lvl_idx[lv]),
      .addr_o(lvl_addr[lv])
    );
  end

  logic [PPN_W-1:0] dec_ppn;
  logic [FLG_W-1:0] dec_flags;
  logic dec_valid, dec_rsvd, dec_ptr, dec_r, dec_w, dec_x, dec_u;

  ptw_pte_decode #(.PTE_W(PTE_W), .PPN_W(PPN_W)) u_dec (
    .pte_i  (mem_rdata_i),
    .ppn_o  (dec_ppn),
    .flags_o(dec_flags),
    .valid_o(dec_valid),
    .rsvd_o (dec_rsvd),
    .ptr_o  (dec_ptr),
    .r_o    (dec_r),
    .w_o    (dec_w),
    .x_o    (dec_x),
    .u_o    (dec_u)
  );

  logic perm_ok;
  ptw_perm_check u_perm (
    .acc_i (acc_q),
    .user_i(user_q),
    .r_i   (dec_r),
    .w_i   (dec_w),
    .x_i   (dec_x),
    .u_i   (dec_u),
    .ok_o  (perm_ok)
  );

  logic super_misal, bad_entry;
  assign super_misal = |dec_ppn[IDX_W-1:0];
  assign bad_entry   = ~dec_valid | dec_rsvd;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_valid_i) state_d = ST_RD_L1;
      ST_RD_L1: state_d = ST_WT_L1;
      ST_WT_L1: if (mem_rvalid_i) begin
        if (bad_entry)                   state_d = ST_FAULT;
        else if (dec_ptr)                state_d = ST_RD_L2;
        else if (super_misal || !perm_ok) state_d = ST_FAULT;
        else                             state_d = ST_DONE;
      end
      ST_RD_L2: state_d = ST_WT_L2;
      ST_WT_L2: if (mem_rvalid_i) begin
        if (bad_entry || dec_ptr || !perm_ok) state_d = ST_FAULT;
        else                                  state_d = ST_DONE;
      end
      ST_DONE, ST_FAULT: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      vpn_q       <= '0;
      acc_q       <= ACC_LOAD;
      user_q      <= 1'b0;
      root_q      <= '0;
      ptr_q       <= '0;
      res_ppn_q   <= '0;
      res_super_q <= 1'b0;
      res_flags_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_valid_i) begin
        vpn_q  <= req_vpn_i;
        acc_q  <= acc_e'(req_acc_i);
        user_q <= req_user_i;
        root_q <= root_ppn_i;
      end
      if (state_q == ST_WT_L1 && state_d == ST_RD_L2) ptr_q <= dec_ppn;
      if (state_d == ST_DONE) begin
        res_super_q <= (state_q == ST_WT_L1);
        res_flags_q <= dec_flags;
        res_ppn_q   <= (state_q == ST_WT_L1)
                     ? {dec_ppn[PPN_W-1:IDX_W], vpn_q[IDX_W-1:0]}
                     : dec_ppn;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign mem_req_o   = (state_q == ST_RD_L1) || (state_q == ST_RD_L2);
  assign mem_addr_o  = (state_q == ST_RD_L2) ? lvl_addr[1] : lvl_addr[0];
  assign done_o      = (state_q == ST_DONE);
  assign fault_o     = (state_q == ST_FAULT);
  assign res_ppn_o   = res_ppn_q;
  assign res_super_o = res_super_q;
  assign res_flags_o = res_flags_q;
endmodule

// File: rtl/ptw_engine_chk.sv
module ptw_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic busy_o,
  input logic mem_req_o,
  input logic mem_rvalid_i,
  input logic done_o,
  input logic fault_o
);
  assert_pulse_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fault_o));
  assert_done_one_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_fault_one_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);
  assert_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> busy_o);
  assert_end_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |=> !busy_o);
  assert_req_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
  assert_single_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);
  assert_no_read_at_end_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o || fault_o) |-> !mem_req_o);
  assert_idle_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_req_o || done_o || fault_o));
endmodule

bind ptw_engine ptw_engine_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .mem_req_o   (mem_req_o),
  .mem_rvalid_i(mem_rvalid_i),
  .done_o      (done_o),
  .fault_o     (fault_o)
);

// File: tb/sim_ptw_engine.sv
module sim_ptw_engine;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [19:0] req_vpn_i = '0;
  logic [1:0]  req_acc_i = '0;
  logic        req_user_i = 1'b0;
  logic [21:0] root_ppn_i = '0;
  logic        busy_o, mem_req_o, done_o, fault_o, res_super_o;
  logic [33:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [21:0] res_ppn_o;
  logic [9:0]  res_flags_o;

  always #4 clk_i = ~clk_i;

  ptw_engine u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_vpn_i, .req_acc_i, .req_user_i,
    .root_ppn_i, .busy_o, .mem_req_o, .mem_addr_o, .mem_rvalid_i,
    .mem_rdata_i, .done_o, .fault_o, .res_ppn_o, .res_super_o, .res_flags_o
  );

  logic [31:0] pt_mem [logic [33:0]];
  int n_cmp = 0, n_bad = 0;
  int nreads = 0;
  logic [33:0] addr_log [4];
  logic        pend = 1'b0;
  logic [33:0] pend_addr = '0;
  int          lat = 0;

  function automatic logic [31:0] rd(input logic [33:0] a);
    return pt_mem.exists(a) ? pt_mem[a] : 32'h0;
  endfunction

  // memory model: 1..3 cycle latency, one request at a time
  always @(negedge clk_i) begin
    mem_rvalid_i <= 1'b0;
    if (pend) begin
      if (lat == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i  <= rd(pend_addr);
        pend <= 1'b0;
      end else lat <= lat - 1;
    end
    if (mem_req_o) begin
      pend      <= 1'b1;
      pend_addr <= mem_addr_o;
      lat       <= int'($urandom % 3);
      if (nreads < 4) addr_log[nreads] <= mem_addr_o;
      nreads    <= nreads + 1;
    end
  end

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic bit perm(input logic [31:0] e, input logic [1:0] acc, input logic usr);
    bit ok;
    case (acc)
      2'd0: ok = e[1];
      2'd1: ok = e[2];
      2'd2: ok = e[3];
      default: ok = 1'b0;
    endcase
    return ok && (usr == e[4]);
  endfunction

  task automatic model(input logic [19:0] vpn, input logic [1:0] acc, input logic usr,
                       input logic [21:0] root, output bit flt, output logic [21:0] ppn,
                       output bit sup, output int nrd, output logic [33:0] a1);
    logic [31:0] e;
    logic [33:0] a2;
    a1 = {root, vpn[19:10], 2'b00};
    e = rd(a1); nrd = 1; sup = 0; ppn = '0; flt = 1;
    if (!e[0] || (e[2] && !e[1])) return;
    if (e[1] | e[2] | e[3]) begin
      if (e[19:10] != 0) return;
      sup = 1; ppn = {e[31:20], vpn[9:0]}; flt = !perm(e, acc, usr);
      return;
    end
    a2 = {e[31:10], vpn[9:0], 2'b00};
    e = rd(a2); nrd = 2;
    if (!e[0] || (e[2] && !e[1]) || !(e[1] | e[2] | e[3])) return;
    ppn = e[31:10]; flt = !perm(e, acc, usr);
  endtask

  task automatic walk(input logic [19:0] vpn, input logic [1:0] acc, input logic usr,
                      input logic [21:0] root, input bit intrude, input string tag);
    bit eflt, esup; logic [21:0] eppn; int enrd; logic [33:0] ea1; int t;
    model(vpn, acc, usr, root, eflt, eppn, esup, enrd, ea1);
    @(negedge clk_i);
    nreads = 0;
    root_ppn_i = root; req_vpn_i = vpn; req_acc_i = acc; req_user_i = usr;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    check(busy_o === 1'b1, "R11 busy after accept", busy_o, 1);
    if (intrude) begin
      // R12: new request and root change while busy
      req_valid_i = 1'b1; req_vpn_i = ~vpn; root_ppn_i = ~root; req_acc_i = 2'd3;
      @(negedge clk_i); @(negedge clk_i);
      req_valid_i = 1'b0;
    end
    t = 0;
    while (!(done_o || fault_o) && t < 100) begin @(negedge clk_i); t++; end
    check(t < 100, {tag, " walk finished"}, t, 0);
    check(fault_o == eflt && done_o == !eflt, {tag, " outcome fault"}, fault_o, eflt);
    if (!eflt && done_o) begin
      check(res_ppn_o == eppn, {tag, " ppn"}, res_ppn_o, eppn);
      check(res_super_o == esup, {tag, " super"}, res_super_o, esup);
    end
    check(nreads == enrd, {tag, " R2 R5 read count"}, nreads, enrd);
    check(addr_log[0] == ea1, {tag, " R1 first addr"}, addr_log[0], ea1);
    @(negedge clk_i);
    check(!done_o && !fault_o && !busy_o, "R11 idle after pulse",
          {done_o, fault_o, busy_o}, 0);
    root_ppn_i = root;
  endtask

  function automatic logic [3:0] leaf_rwx(input int k);
    case (k % 5)
      0: return 4'b0011;
      1: return 4'b0111;
      2: return 4'b1001;
      3: return 4'b1011;
      default: return 4'b1111;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [21:0] root, ptr;
    logic [19:0] vpn;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    check(!busy_o && !mem_req_o && !done_o && !fault_o, "R13 reset outputs",
          {busy_o, mem_req_o, done_o, fault_o}, 0);
    rst_ni = 1'b1;

    // directed
    root = 22'h12345; ptr = 22'h0abcd; vpn = 20'h2a5c3;
    pt_mem.delete();
    pt_mem[{root, vpn[19:10], 2'b00}] = {ptr, 10'h001};
    pt_mem[{ptr, vpn[9:0], 2'b00}]    = {22'h3f00f, 10'h003};
    walk(vpn, 2'd0, 1'b0, root, 1'b0, "R4 R2 4K load");
    walk(vpn, 2'd1, 1'b0, root, 1'b0, "R9 store on read-only");
    walk(vpn, 2'd0, 1'b1, root, 1'b0, "R10 user on supervisor page");
    walk(vpn, 2'd0, 1'b0, root, 1'b1, "R12 ignore while busy");
    pt_mem[{ptr, vpn[9:0], 2'b00}] = {22'h00777, 10'h019};
    walk(vpn, 2'd2, 1'b1, root, 1'b0, "R9 R10 user fetch");
    walk(vpn, 2'd2, 1'b0, root, 1'b0, "R10 supervisor on user page");
    walk(vpn, 2'd3, 1'b1, root, 1'b0, "R9 reserved access");
    pt_mem[{ptr, vpn[9:0], 2'b00}] = {22'h00777, 10'h001};
    walk(vpn, 2'd0, 1'b0, root, 1'b0, "R7 pointer at level 2");
    pt_mem[{ptr, vpn[9:0], 2'b00}] = {22'h00777, 10'h006};
    walk(vpn, 2'd0, 1'b0, root, 1'b0, "R5 invalid at level 2");
    pt_mem[{root, vpn[19:10], 2'b00}] = {12'hfed, 10'h000, 10'h00f};
    walk(vpn, 2'd1, 1'b0, root, 1'b0, "R3 superpage");
    pt_mem[{root, vpn[19:10], 2'b00}] = {12'hfed, 10'h200, 10'h00f};
    walk(vpn, 2'd1, 1'b0, root, 1'b0, "R8 misaligned superpage");
    pt_mem[{root, vpn[19:10], 2'b00}] = {12'hfed, 10'h000, 10'h005};
    walk(vpn, 2'd1, 1'b0, root, 1'b0, "R6 write-only reserved");
    pt_mem[{root, vpn[19:10], 2'b00}] = {12'hfed, 10'h000, 10'h00e};
    walk(vpn, 2'd0, 1'b0, root, 1'b0, "R5 invalid at level 1");

    // constrained random
    for (int i = 0; i < 300; i++) begin
      int k1, k2;
      logic [31:0] e1, e2;
      root = 22'($urandom); ptr = 22'($urandom); vpn = 20'($urandom);
      k1 = int'($urandom % 8); k2 = int'($urandom % 8);
      pt_mem.delete();
      case (k1)
        0: e1 = {ptr, 5'($urandom), 4'($urandom), 1'b0};
        1: e1 = {ptr, 5'($urandom), 1'($urandom), 3'b010, 1'b1} | 32'h4;
        2, 3: e1 = {ptr[21:10], 10'h0, 5'($urandom), leaf_rwx(int'($urandom)), 1'b0} | 32'h1;
        4: e1 = {ptr[21:10], 10'h1 << ($urandom % 10), 5'($urandom), leaf_rwx(int'($urandom)), 1'b0} | 32'h1;
        default: e1 = {ptr, 5'($urandom), 1'($urandom), 4'b0001};
      endcase
      if (k1 == 1) e1[3:1] = ($urandom % 2) ? 3'b010 : 3'b110;
      case (k2)
        0: e2 = {22'($urandom), 5'($urandom), 4'($urandom), 1'b0};
        1: e2 = {22'($urandom), 6'($urandom), 3'b010, 1'b1};
        2: e2 = {22'($urandom), 6'($urandom), 4'b0001};
        default: e2 = {22'($urandom), 5'($urandom), leaf_rwx(int'($urandom)), 1'b0} | 32'h1;
      endcase
      pt_mem[{root, vpn[19:10], 2'b00}] = e1;
      pt_mem[{e1[31:10], vpn[9:0], 2'b00}] = e2;
      walk(vpn, 2'($urandom % 3), 1'($urandom), root, ($urandom % 8) == 0, "R9 R10 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule